// File: doc/BRIEF.md
# In-Order Retirement Queue

This block keeps program order for a dispatch-in-order, execute-out-of-order pipeline. Each dispatched instruction is written into the next slot of an eight-slot circular queue, and the queue returns that slot's index so an execution unit can report completion against it later. A finish report marks the slot done and can flag an exception. Each cycle the block looks at the oldest two slots and retires every leading slot that is done and has no exception, up to two per cycle. A retirement is the moment at which the instruction's result may be written to architectural state, so the block raises a per-slot commit enable whenever the retiring instruction has a destination.

A branch that writes neither the link nor the count register is folded away at dispatch: it never occupies a slot. A branch that writes one of those two registers takes a slot as usual. It is never sent to an execution unit, so the block marks it done when it is written. The queue-full stall is computed from the occupancy left after the current cycle's retirements, so a full queue that retires in a cycle still accepts a dispatch in that same cycle. A flush empties the queue at once.

Top module: `crq_inorder_retire`

## Requirements
- R1: After reset the queue is empty: no retire strobe, q_full low, exc_pending low, and disp_idx is 0.
- R2: Each accepted non-folded dispatch takes the slot shown on disp_idx in that cycle. Slots are handed out in increasing order and wrap from 7 back to 0.
- R3: q_full is high when all eight slots are occupied and nothing retires in the current cycle. While q_full is high a non-folded dispatch is ignored and takes no slot.
- R4: Retirement follows dispatch order. ret_valid[0] carries the oldest slot and ret_valid[1] the next one, with their tags on ret_tag[0] and ret_tag[1]. At most two instructions retire per cycle.
- R5: A slot retires only when every older slot retires in the same cycle or has already retired. A finished younger slot waits behind an unfinished oldest slot.
- R6: A dispatch with disp_branch=1 and disp_lrctr=0 takes no slot. disp_idx does not advance, and the dispatch is accepted even while q_full is high.
- R7: A dispatch with disp_branch=1 and disp_lrctr=1 takes a slot already marked done. It retires in the cycle after its dispatch with no finish report.
- R8: commit_en[k] is high exactly when ret_valid[k] is high and that slot's destination kind is not 0. Destination kind encoding: 0 none, 1 integer, 2 floating-point, 3 vector.
- R9: A slot finished with fin_exc=1 never retires and blocks every younger slot. While it is the oldest slot, exc_pending is high and no retire strobe is raised.
- R10: flush empties the queue on the next edge: all slots are freed, exc_pending drops, and the next dispatch gets slot 0.
- R11: When the queue is full and the oldest slot retires, q_full is low in that cycle, and a dispatch in that cycle is accepted into the freed position.
- R12: A finish report for a slot that is not occupied is ignored. A later dispatch into that slot is not done until its own finish report arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request |
| disp_tag | input | TAG_W | Instruction tag stored in the slot |
| disp_dst | input | 2 | Destination kind (0 none, 1 integer, 2 floating-point, 3 vector) |
| disp_branch | input | 1 | Dispatched instruction is a branch |
| disp_lrctr | input | 1 | Branch writes the link or count register |
| disp_idx | output | IDX_W | Slot the current dispatch takes |
| q_full | output | 1 | Dispatch stall: no slot free after this cycle's retirements |
| fin_valid | input | 1 | Finish report |
| fin_idx | input | IDX_W | Slot being finished |
| fin_exc | input | 1 | Finished instruction raised an exception |
| flush | input | 1 | Empty the queue |
| ret_valid | output | RETIRE_W | Retire strobes, bit 0 is the oldest slot |
| ret_tag | output | RETIRE_W x TAG_W | Tags of the retiring slots |
| ret_dst | output | RETIRE_W x 2 | Destination kinds of the retiring slots |
| commit_en | output | RETIRE_W | Write enable to architectural state per retire slot |
| exc_pending | output | 1 | Oldest slot is done with an exception |

## Verification
The assertions check on every cycle that occupancy never goes above eight, that a full queue does not move the allocation pointer, that a folded branch never takes a slot, that allocation only lands on a free slot, that a link/count branch is done on arrival, that the retire strobes always form a run starting at the oldest slot, that a pending exception stops all retirement, and that flush frees every slot. Only the bench scenarios can show the actual tag sequence coming out in dispatch order across a pointer wrap, two-wide retirement, dispatch accepted into the slot being freed in the same cycle, and a finish report to an empty slot leaving no trace.

// File: rtl/crq_pkg.sv
package crq_pkg;

   // Destination kind of a queued instruction; 0 means nothing to commit.
   typedef enum logic [1:0] {
      DST_NONE = 2'd0,
      DST_INT  = 2'd1,
      DST_FP   = 2'd2,
      DST_VEC  = 2'd3
   } dst_kind_e;

   localparam int DST_W = 2;

endpackage

// File: rtl/crq_ptr_ctl.sv
module crq_ptr_ctl #(
   parameter int DEPTH    = 8,
   parameter int RETIRE_W = 2,
   localparam int IDX_W   = $clog2(DEPTH),
   localparam int CNT_W   = $clog2(DEPTH + 1),
   localparam int NR_W    = $clog2(RETIRE_W + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             disp_want,
   input  logic [NR_W-1:0]  n_ret,
   output logic             alloc,
   output logic             full,
   output logic [IDX_W-1:0] head,
   output logic [IDX_W-1:0] tail,
   output logic [CNT_W-1:0] count
);

   if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 2) begin : g_bad_depth
      $error("crq_ptr_ctl: DEPTH must be a power of two and at least 2");
   end

   // Full uses the occupancy left after this cycle's retirements.
   assign full  = (count == CNT_W'(DEPTH)) && (n_ret == '0);
   assign alloc = disp_want && !full;

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         head  <= '0;
         tail  <= '0;
         count <= '0;
      end else begin
         head  <= head + IDX_W'(n_ret);
         tail  <= tail + IDX_W'(alloc);
         count <= count + CNT_W'(alloc) - CNT_W'(n_ret);
      end
   end

   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));

   p_full_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (full && disp_want && !flush) |=> (tail == $past(tail)));

endmodule

// File: rtl/crq_entry_array.sv
module crq_entry_array #(
   parameter int DEPTH  = 8,
   parameter int TAG_W  = 6,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int DST_W = crq_pkg::DST_W
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        flush,
   input  logic                        alloc_en,
   input  logic [IDX_W-1:0]            alloc_idx,
   input  logic [TAG_W-1:0]            alloc_tag,
   input  logic [DST_W-1:0]            alloc_dst,
   input  logic                        alloc_done,
   input  logic                        fin_en,
   input  logic [IDX_W-1:0]            fin_idx,
   input  logic                        fin_exc,
   input  logic [DEPTH-1:0]            clr,
   output logic [DEPTH-1:0]            v,
   output logic [DEPTH-1:0]            done,
   output logic [DEPTH-1:0]            exc,
   output logic [DEPTH-1:0][TAG_W-1:0] tag,
   output logic [DEPTH-1:0][DST_W-1:0] dst
);

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      logic             v_r, done_r, exc_r;
      logic [TAG_W-1:0] tag_r;
      logic [DST_W-1:0] dst_r;
      logic             hit_alloc, hit_fin;

      assign hit_alloc = alloc_en && (alloc_idx == IDX_W'(g));
      assign hit_fin   = fin_en && (fin_idx == IDX_W'(g)) && v_r && !clr[g];

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            v_r    <= 1'b0;
            done_r <= 1'b0;
            exc_r  <= 1'b0;
            tag_r  <= '0;
            dst_r  <= '0;
         end else if (flush) begin
            v_r    <= 1'b0;
            done_r <= 1'b0;
            exc_r  <= 1'b0;
         end else if (hit_alloc) begin
            // Allocation wins over a retire clear of the same slot.
            v_r    <= 1'b1;
            done_r <= alloc_done;
            exc_r  <= 1'b0;
            tag_r  <= alloc_tag;
            dst_r  <= alloc_dst;
         end else begin
            if (clr[g]) begin
               v_r    <= 1'b0;
               done_r <= 1'b0;
            end
            if (hit_fin) begin
               done_r <= 1'b1;
               exc_r  <= fin_exc;
            end
         end
      end

      assign v[g]    = v_r;
      assign done[g] = done_r;
      assign exc[g]  = exc_r;
      assign tag[g]  = tag_r;
      assign dst[g]  = dst_r;
   end

   p_alloc_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_en && !flush) |-> (!v[alloc_idx] || clr[alloc_idx]));

endmodule

// File: rtl/crq_retire_sel.sv
module crq_retire_sel #(
   parameter int DEPTH    = 8,
   parameter int TAG_W    = 6,
   parameter int RETIRE_W = 2,
   localparam int IDX_W   = $clog2(DEPTH),
   localparam int NR_W    = $clog2(RETIRE_W + 1),
   localparam int DST_W   = crq_pkg::DST_W
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [IDX_W-1:0]               head,
   input  logic [DEPTH-1:0]               v,
   input  logic [DEPTH-1:0]               done,
   input  logic [DEPTH-1:0]               exc,
   input  logic [DEPTH-1:0][TAG_W-1:0]    tag,
   input  logic [DEPTH-1:0][DST_W-1:0]    dst,
   output logic [RETIRE_W-1:0]            ret_valid,
   output logic [RETIRE_W-1:0][TAG_W-1:0] ret_tag,
   output logic [RETIRE_W-1:0][DST_W-1:0] ret_dst,
   output logic [RETIRE_W-1:0]            commit_en,
   output logic [DEPTH-1:0]               clr,
   output logic [NR_W-1:0]                n_ret,
   output logic                           exc_hold
);
   import crq_pkg::*;

   if (RETIRE_W < 1 || RETIRE_W > DEPTH) begin : g_bad_width
      $error("crq_retire_sel: RETIRE_W must lie between 1 and DEPTH");
   end

   logic [RETIRE_W-1:0][IDX_W-1:0] slot_idx;
   logic [RETIRE_W-1:0]            slot_ok;

   for (genvar k = 0; k < RETIRE_W; k++) begin : g_port
      assign slot_idx[k] = head + IDX_W'(k);
      assign slot_ok[k]  = v[slot_idx[k]] && done[slot_idx[k]] && !exc[slot_idx[k]];
      if (k == 0) begin : g_oldest
         assign ret_valid[k] = slot_ok[k];
      end else begin : g_younger
         assign ret_valid[k] = ret_valid[k-1] && slot_ok[k];
      end
      assign ret_tag[k]   = tag[slot_idx[k]];
      assign ret_dst[k]   = dst[slot_idx[k]];
      assign commit_en[k] = ret_valid[k] && (dst[slot_idx[k]] != DST_NONE);
   end

   always_comb begin
      clr = '0;
      for (int k = 0; k < RETIRE_W; k++) begin
         if (ret_valid[k]) clr[slot_idx[k]] = 1'b1;
      end
   end

   assign n_ret    = NR_W'($countones(ret_valid));
   assign exc_hold = v[head] && done[head] && exc[head];

   p_exc_stops_r9: assert property (@(posedge clk) disable iff (!rst_n)
      exc_hold |-> (ret_valid == '0));

   p_in_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((ret_valid & (ret_valid + RETIRE_W'(1))) == '0));

endmodule

// File: rtl/crq_inorder_retire.sv
module crq_inorder_retire #(
   parameter int DEPTH    = 8,
   parameter int TAG_W    = 6,
   parameter int RETIRE_W = 2,
   localparam int IDX_W   = $clog2(DEPTH),
   localparam int CNT_W   = $clog2(DEPTH + 1),
   localparam int NR_W    = $clog2(RETIRE_W + 1)
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           disp_valid,
   input  logic [TAG_W-1:0]               disp_tag,
   input  logic [1:0]                     disp_dst,
   input  logic                           disp_branch,
   input  logic                           disp_lrctr,
   output logic [IDX_W-1:0]               disp_idx,
   output logic                           q_full,
   input  logic                           fin_valid,
   input  logic [IDX_W-1:0]               fin_idx,
   input  logic                           fin_exc,
   input  logic                           flush,
   output logic [RETIRE_W-1:0]            ret_valid,
   output logic [RETIRE_W-1:0][TAG_W-1:0] ret_tag,
   output logic [RETIRE_W-1:0][1:0]       ret_dst,
   output logic [RETIRE_W-1:0]            commit_en,
   output logic                           exc_pending
);

   if (TAG_W < 1) begin : g_bad_tag
      $error("crq_inorder_retire: TAG_W must be at least 1");
   end

   logic                    fold, disp_want, alloc, pre_done;
   logic [IDX_W-1:0]        head, tail;
   logic [CNT_W-1:0]        count;
   logic [NR_W-1:0]         n_ret;
   logic [DEPTH-1:0]        v, done, exc, clr;
   logic [DEPTH-1:0][TAG_W-1:0] tag;
   logic [DEPTH-1:0][1:0]   dst;

   // Branches that write neither link nor count register are folded away.
   assign fold      = disp_branch && !disp_lrctr;
   assign disp_want = disp_valid && !fold;
   assign pre_done  = disp_branch && disp_lrctr;
   assign disp_idx  = tail;

   crq_ptr_ctl #(.DEPTH(DEPTH), .RETIRE_W(RETIRE_W)) u_ptr (
      .clk(clk), .rst_n(rst_n), .flush(flush), .disp_want(disp_want),
      .n_ret(n_ret), .alloc(alloc), .full(q_full),
      .head(head), .tail(tail), .count(count)
   );

   crq_entry_array #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_arr (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .alloc_en(alloc), .alloc_idx(tail), .alloc_tag(disp_tag),
      .alloc_dst(disp_dst), .alloc_done(pre_done),
      .fin_en(fin_valid), .fin_idx(fin_idx), .fin_exc(fin_exc),
      .clr(clr), .v(v), .done(done), .exc(exc), .tag(tag), .dst(dst)
   );

   crq_retire_sel #(.DEPTH(DEPTH), .TAG_W(TAG_W), .RETIRE_W(RETIRE_W)) u_sel (
      .clk(clk), .rst_n(rst_n), .head(head),
      .v(v), .done(done), .exc(exc), .tag(tag), .dst(dst),
      .ret_valid(ret_valid), .ret_tag(ret_tag), .ret_dst(ret_dst),
      .commit_en(commit_en), .clr(clr), .n_ret(n_ret), .exc_hold(exc_pending)
   );

   p_fold_no_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_valid && fold && !flush) |=> (tail == $past(tail)));

   p_lrctr_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc && pre_done && !flush) |=> done[$past(tail)]);

   p_flush_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> ((v == '0) && (count == '0)));

endmodule

// File: tb/crq_inorder_retire_test.sv
module crq_inorder_retire_test;
   localparam int TAG_W = 6;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            disp_valid = 1'b0;
   logic [TAG_W-1:0] disp_tag = '0;
   logic [1:0]      disp_dst = '0;
   logic            disp_branch = 1'b0, disp_lrctr = 1'b0;
   logic [2:0]      disp_idx;
   logic            q_full;
   logic            fin_valid = 1'b0;
   logic [2:0]      fin_idx = '0;
   logic            fin_exc = 1'b0;
   logic            flush = 1'b0;
   logic [1:0]      ret_valid;
   logic [1:0][TAG_W-1:0] ret_tag;
   logic [1:0][1:0] ret_dst;
   logic [1:0]      commit_en;
   logic            exc_pending;

   int n_chk = 0, n_fail = 0;

   always #10 clk = ~clk;

   crq_inorder_retire uut (
      .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_tag(disp_tag),
      .disp_dst(disp_dst), .disp_branch(disp_branch), .disp_lrctr(disp_lrctr),
      .disp_idx(disp_idx), .q_full(q_full), .fin_valid(fin_valid),
      .fin_idx(fin_idx), .fin_exc(fin_exc), .flush(flush),
      .ret_valid(ret_valid), .ret_tag(ret_tag), .ret_dst(ret_dst),
      .commit_en(commit_en), .exc_pending(exc_pending)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic idle();
      disp_valid = 1'b0; disp_branch = 1'b0; disp_lrctr = 1'b0;
      fin_valid = 1'b0; fin_exc = 1'b0; flush = 1'b0;
   endtask

   // Drive one dispatch for one edge; check the slot it is given.
   task automatic do_disp(input int t, input int d, input bit br, input bit lr,
                          input int exp_idx, input string req);
      @(negedge clk);
      disp_valid = 1'b1; disp_tag = TAG_W'(t); disp_dst = 2'(d);
      disp_branch = br; disp_lrctr = lr;
      #1 chk(req, disp_idx, exp_idx);
      @(posedge clk); #1 idle();
   endtask

   task automatic do_fin(input int idx, input bit e);
      @(negedge clk);
      fin_valid = 1'b1; fin_idx = 3'(idx); fin_exc = e;
      @(posedge clk); #1 idle();
   endtask

   task automatic do_flush();
      @(negedge clk);
      flush = 1'b1;
      @(posedge clk); #1 idle();
   endtask

   task automatic peek();
      @(negedge clk); #1;
   endtask

   task automatic t_reset();
      peek();
      chk("R1 ret_valid", ret_valid, 0);
      chk("R1 q_full", q_full, 0);
      chk("R1 exc_pending", exc_pending, 0);
      chk("R1 disp_idx", disp_idx, 0);
   endtask

   task automatic t_two_wide();
      do_disp(10, 1, 0, 0, 0, "R2 slot0");
      do_disp(11, 1, 0, 0, 1, "R2 slot1");
      do_disp(12, 2, 0, 0, 2, "R2 slot2");
      do_fin(1, 0);
      do_fin(2, 0);
      peek();
      chk("R5 younger waits", ret_valid, 0);
      do_fin(0, 0);
      peek();
      chk("R4 two retire", ret_valid, 3);
      chk("R4 tag0", ret_tag[0], 10);
      chk("R4 tag1", ret_tag[1], 11);
      chk("R8 commit both", commit_en, 3);
      peek();
      chk("R4 third retire", ret_valid, 1);
      chk("R4 third tag", ret_tag[0], 12);
      chk("R8 third dst", ret_dst[0], 2);
      peek();
      chk("R4 drained", ret_valid, 0);
   endtask

   task automatic t_no_dest();
      do_disp(20, 0, 0, 0, 3, "R2 slot3");
      do_fin(3, 0);
      peek();
      chk("R8 retire no dest", ret_valid, 1);
      chk("R8 no commit", commit_en, 0);
   endtask

   task automatic t_lrctr();
      do_disp(21, 1, 1, 1, 4, "R7 slot4");
      peek();
      chk("R7 retires unreported", ret_valid, 1);
      chk("R7 tag", ret_tag[0], 21);
      chk("R8 lrctr commit", commit_en, 1);
   endtask

   task automatic t_fold();
      do_disp(22, 0, 1, 0, 5, "R6 folded sees slot5");
      peek();
      chk("R6 no retire", ret_valid, 0);
      chk("R6 idx kept", disp_idx, 5);
      do_disp(23, 1, 0, 0, 5, "R6 next gets slot5");
      do_flush();
      peek();
      chk("R10 idx reset", disp_idx, 0);
      chk("R10 empty", ret_valid, 0);
      chk("R10 not full", q_full, 0);
   endtask

   task automatic t_full();
      int exp_t[8] = '{31, 32, 33, 34, 35, 36, 37, 42};
      for (int i = 0; i < 8; i++) do_disp(30 + i, 1, 0, 0, i, "R2 wrap fill");
      peek();
      chk("R3 full", q_full, 1);
      chk("R2 idx wrapped", disp_idx, 0);
      do_disp(40, 1, 0, 0, 0, "R3 blocked dispatch");
      peek();
      chk("R3 still full", q_full, 1);
      do_disp(41, 0, 1, 0, 0, "R6 fold while full");
      peek();
      chk("R6 full unchanged", q_full, 1);
      do_fin(0, 0);
      // Oldest retires this cycle: stall drops and dispatch lands in slot 0.
      @(negedge clk);
      disp_valid = 1'b1; disp_tag = 42; disp_dst = 1;
      #1;
      chk("R11 not full while retiring", q_full, 0);
      chk("R11 retiring", ret_valid, 1);
      chk("R11 tag", ret_tag[0], 30);
      chk("R11 slot", disp_idx, 0);
      @(posedge clk); #1 idle();
      peek();
      chk("R11 full again", q_full, 1);
      do_fin(0, 0);
      for (int i = 7; i >= 2; i--) do_fin(i, 0);
      peek();
      chk("R5 head unfinished", ret_valid, 0);
      do_fin(1, 0);
      for (int c = 0; c < 4; c++) begin
         peek();
         chk("R4 pair valid", ret_valid, 3);
         chk("R4 order lo", ret_tag[0], exp_t[2*c]);
         chk("R4 order hi", ret_tag[1], exp_t[2*c+1]);
      end
      peek();
      chk("R4 empty after drain", ret_valid, 0);
      chk("R3 no overflow entry", q_full, 0);
   endtask

   task automatic t_exc();
      do_flush();
      do_disp(50, 1, 0, 0, 0, "R2 exc slot0");
      do_disp(51, 1, 0, 0, 1, "R2 exc slot1");
      do_disp(52, 1, 0, 0, 2, "R2 exc slot2");
      do_fin(2, 0);
      do_fin(1, 1);
      do_fin(0, 0);
      peek();
      chk("R9 older retires", ret_valid, 1);
      chk("R9 older tag", ret_tag[0], 50);
      chk("R9 not yet pending", exc_pending, 0);
      peek();
      chk("R9 blocked", ret_valid, 0);
      chk("R9 pending", exc_pending, 1);
      peek();
      chk("R9 stays blocked", ret_valid, 0);
      do_flush();
      peek();
      chk("R10 exc cleared", exc_pending, 0);
   endtask

   task automatic t_stray_fin();
      do_fin(0, 0);
      do_disp(60, 1, 0, 0, 0, "R12 slot0");
      peek();
      chk("R12 stray finish ignored", ret_valid, 0);
      do_fin(0, 0);
      peek();
      chk("R12 real finish", ret_valid, 1);
      chk("R12 tag", ret_tag[0], 60);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      t_reset();
      t_two_wide();
      t_no_dest();
      t_lrctr();
      t_fold();
      t_full();
      t_exc();
      t_stray_fin();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule